// File: doc/BRIEF.md
# Flash command sequence interpreter

This block is a clock-synchronous model of the command front end of a 64K x 16 parallel NOR flash. A host drives a write strobe, a read strobe, one 16-bit address bus and 16-bit write data, and receives 16-bit read data one cycle after each read strobe. Write access is guarded by a fixed unlock ritual. Two writes with fixed address and data must come before any command. Erase needs a second unlock pair before its final write.

Program and erase run as timed busy periods. Each period lasts a parameterised number of clock cycles, so that simulation stays short. While busy, the block ignores every write. Reads during that time return completion status bits instead of memory contents. An identification mode maps two fixed code words onto the lowest two addresses.

The array is a slice of the full space that keeps the sector structure. It holds 32 sectors of 2K words. Only the low `KEEP_LOG` address bits are stored inside each sector, so word addresses that differ only in bits 10 to `KEEP_LOG` alias.

Top module: `nor_cmd_front`

## Requirements
- R1: After reset `busy` is 0, `rdata` is 0000h and every stored word reads FFFFh.
- R2: With no operation running, a read strobe at address A loads `rdata` on the next clock edge. The value is the word stored for A; outside identification mode this holds for every address.
- R3: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by a fourth write (address W, data D), start a program. The word at W then becomes its old value AND D, so programming can only clear bits.
- R4: `busy` rises on the clock edge that takes the final write of a program or erase. It stays high for exactly `PROG_CYCLES`, `SECT_CYCLES` or `CHIP_CYCLES` cycles respectively.
- R5: A read while busy returns a status word. Bit 7 is the inverse of bit 7 of the word being programmed, or 0 during an erase. Bit 6 is 0 on the first busy read after a start and inverts on each later busy read. All other bits are 0.
- R6: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh, followed by 30h at any address A, erase one sector. The sector is address bits 15:11 of A. Every word of that sector becomes FFFFh and other sectors keep their contents.
- R7: The same five writes followed by 10h@5555h set every stored word to FFFFh.
- R8: Command matching looks only at address bits 14:0 and data bits 7:0. Bit 15 of the address and data bits 15:8 may take any value.
- R9: A write that does not match the expected step of a sequence drops the sequence back to its first step. Nothing is programmed or erased.
- R10: While `busy` is high every write is ignored, including complete command sequences.
- R11: AAh@5555h, 55h@2AAAh, 90h@5555h enters identification mode. There, a read with address bits 15:1 all zero returns 00BFh when bit 0 is 0 and 2788h when bit 0 is 1. Any other address returns the array word.
- R12: Identification mode is left by AAh@5555h, 55h@2AAAh, F0h@5555h, or by one write of F0h (low byte) to any address when no sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe, result in `rdata` one cycle later |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| busy | output | 1 | High while a program or erase runs |

## Verification
The assertions assume that the host never raises `wr_en` and `rd_en` in the same cycle. They also assume that a read issued in the cycle of the final command write does not need to see the status word. The stimulus keeps to this because every write and every read uses its own strobe cycle, followed by an idle cycle.

The busy-time checks assume that no write arrives while busy can be accepted. To test this, the stimulus deliberately fires a full program sequence inside a busy window and then reads the target word back. Status reads are issued only after the start edge, so the toggle bit is seen to begin at 0 and alternate.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLK1,
        ST_UNLK2,
        ST_PROG,
        ST_ERA1,
        ST_ERA2,
        ST_ERA3
    } step_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT,
        OP_CHIP
    } op_e;

    typedef struct packed {
        step_e step;
        logic  id_mode;
    } seq_s;

    localparam logic [14:0] KEY_ADDR_A = 15'h5555;
    localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  CMD_PROG   = 8'hA0;
    localparam logic [7:0]  CMD_ERASE  = 8'h80;
    localparam logic [7:0]  CMD_IDIN   = 8'h90;
    localparam logic [7:0]  CMD_IDOUT  = 8'hF0;
    localparam logic [7:0]  CMD_CHIP   = 8'h10;
    localparam logic [7:0]  CMD_SECT   = 8'h30;

endpackage

// File: rtl/nor_seq_decode.sv
module nor_seq_decode
    import nor_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic        busy_i,
    input  logic [14:0] cmd_addr_i,
    input  logic [7:0]  cmd_data_i,
    output op_e         op_o,
    output logic        id_mode_o
);

    seq_s seq_d, seq_q;
    logic at_a, at_b;

    assign at_a = (cmd_addr_i == KEY_ADDR_A);
    assign at_b = (cmd_addr_i == KEY_ADDR_B);

    always_comb begin
        seq_d = seq_q;
        op_o  = OP_NONE;
        if (wr_en_i && !busy_i) begin
            seq_d.step = ST_IDLE;
            unique case (seq_q.step)
                ST_IDLE: begin
                    if (at_a && cmd_data_i == KEY_DATA_A) seq_d.step = ST_UNLK1;
                    else if (cmd_data_i == CMD_IDOUT)     seq_d.id_mode = 1'b0;
                end
                ST_UNLK1: begin
                    if (at_b && cmd_data_i == KEY_DATA_B) seq_d.step = ST_UNLK2;
                end
                ST_UNLK2: begin
                    if (at_a) begin
                        case (cmd_data_i)
                            CMD_PROG:  seq_d.step    = ST_PROG;
                            CMD_ERASE: seq_d.step    = ST_ERA1;
                            CMD_IDIN:  seq_d.id_mode = 1'b1;
                            CMD_IDOUT: seq_d.id_mode = 1'b0;
                            default:   seq_d.step    = ST_IDLE;
                        endcase
                    end
                end
                ST_PROG: op_o = OP_PROG;
                ST_ERA1: begin
                    if (at_a && cmd_data_i == KEY_DATA_A) seq_d.step = ST_ERA2;
                end
                ST_ERA2: begin
                    if (at_b && cmd_data_i == KEY_DATA_B) seq_d.step = ST_ERA3;
                end
                ST_ERA3: begin
                    if (at_a && cmd_data_i == CMD_CHIP) op_o = OP_CHIP;
                    else if (cmd_data_i == CMD_SECT)    op_o = OP_SECT;
                end
                default: seq_d.step = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{step: ST_IDLE, id_mode: 1'b0};
        else        seq_q <= seq_d;
    end

    assign id_mode_o = seq_q.id_mode;

    // R10
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (op_o == OP_NONE));

    // R9
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || busy_i) |=> $stable(seq_q));

endmodule

// File: rtl/nor_op_timer.sv
module nor_op_timer
    import nor_cmd_pkg::*;
#(
    parameter int PROG_CYCLES = 8,
    parameter int SECT_CYCLES = 20,
    parameter int CHIP_CYCLES = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  op_e  op_i,
    output logic busy_o
);

    localparam int MAX_A  = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
    localparam int MAX_C  = (MAX_A > CHIP_CYCLES) ? MAX_A : CHIP_CYCLES;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case (op_i)
            OP_PROG: cnt_d = CNT_W'(PROG_CYCLES);
            OP_SECT: cnt_d = CNT_W'(SECT_CYCLES);
            OP_CHIP: cnt_d = CNT_W'(CHIP_CYCLES);
            default: if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R4
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_NONE) |=> busy_o);

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_C));

endmodule

// File: rtl/nor_word_array.sv
module nor_word_array #(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 16,
    parameter int KEEP_LOG      = 3,
    parameter int SECT_SPAN_LOG = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              prog_i,
    input  logic              sect_i,
    input  logic              chip_i,
    output logic [DATA_W-1:0] word_o
);

    localparam int SECT_BITS = ADDR_W - SECT_SPAN_LOG;
    localparam int IDX_W     = SECT_BITS + KEEP_LOG;
    localparam int DEPTH     = 1 << IDX_W;
    localparam int WPS       = 1 << KEEP_LOG;

    logic [DATA_W-1:0]    mem_d [DEPTH];
    logic [DATA_W-1:0]    mem_q [DEPTH];
    logic [SECT_BITS-1:0] sect_sel;
    logic [IDX_W-1:0]     idx;
    logic                 unused_addr_bits;

    assign sect_sel = addr_i[ADDR_W-1:SECT_SPAN_LOG];
    assign idx      = {sect_sel, addr_i[KEEP_LOG-1:0]};
    assign word_o   = mem_q[idx];
    assign unused_addr_bits = ^addr_i[SECT_SPAN_LOG-1:KEEP_LOG];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (chip_i || (sect_i && (i / WPS) == int'(sect_sel)))
                mem_d[i] = '1;
        end
        if (prog_i) mem_d[idx] = mem_q[idx] & data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    // R3
    prog_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_i |=> ((mem_q[$past(idx)] & ~$past(word_o)) == '0));

    // R7
    chip_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_i |=> (mem_q[0] == '1 && mem_q[DEPTH-1] == '1));

endmodule

// File: rtl/nor_cmd_front.sv
module nor_cmd_front
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 16,
    parameter int KEEP_LOG      = 3,
    parameter int SECT_SPAN_LOG = 11,
    parameter int PROG_CYCLES   = 8,
    parameter int SECT_CYCLES   = 20,
    parameter int CHIP_CYCLES   = 30,
    parameter logic [DATA_W-1:0] MAKER_CODE = 16'h00BF,
    parameter logic [DATA_W-1:0] PART_CODE  = 16'h2788
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy
);

    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              tog;
        logic              poll;
    } rd_s;

    rd_s               r_d, r_q;
    op_e               op;
    logic              id_mode;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] status;

    nor_seq_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .busy_i     (busy),
        .cmd_addr_i (addr[14:0]),
        .cmd_data_i (wdata[7:0]),
        .op_o       (op),
        .id_mode_o  (id_mode)
    );

    nor_op_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .SECT_CYCLES (SECT_CYCLES),
        .CHIP_CYCLES (CHIP_CYCLES)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op),
        .busy_o (busy)
    );

    nor_word_array #(
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .KEEP_LOG      (KEEP_LOG),
        .SECT_SPAN_LOG (SECT_SPAN_LOG)
    ) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (addr),
        .data_i (wdata),
        .prog_i (op == OP_PROG),
        .sect_i (op == OP_SECT),
        .chip_i (op == OP_CHIP),
        .word_o (arr_word)
    );

    always_comb begin
        r_d    = r_q;
        status = '0;
        status[POLL_BIT] = r_q.poll;
        status[TOG_BIT]  = r_q.tog;
        if (op != OP_NONE) begin
            r_d.tog  = 1'b0;
            r_d.poll = (op == OP_PROG) ? ~(arr_word[POLL_BIT] & wdata[POLL_BIT]) : 1'b0;
        end
        if (rd_en) begin
            if (busy) begin
                r_d.rdata = status;
                r_d.tog   = ~r_q.tog;
            end else if (id_mode && addr[ADDR_W-1:1] == '0) begin
                r_d.rdata = addr[0] ? PART_CODE : MAKER_CODE;
            end else begin
                r_d.rdata = arr_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata = r_q.rdata;

    // R5
    status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> ((rdata & ~DATA_W'(16'h00C0)) == '0));

    // R4
    busy_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    // R2
    quiet_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/nor_cmd_front_bench.sv
module nor_cmd_front_bench;

    localparam int PROG_N = 8;
    localparam int SECT_N = 20;
    localparam int CHIP_N = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy;

    int n_cmp = 0;
    int n_bad = 0;
    logic        rd_seen = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    nor_cmd_front #(
        .PROG_CYCLES (PROG_N),
        .SECT_CYCLES (SECT_N),
        .CHIP_CYCLES (CHIP_N)
    ) u_nor_cmd_front (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .busy  (busy)
    );

    always @(posedge clk) rd_seen <= rd_en;

    // monitor: pops one expected word per completed read
    always @(negedge clk) begin
        if (rd_seen) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected read result act=%h exp=none", rdata);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s act=%h exp=%h", t, rdata, e);
                end
            end
        end
    end

    task automatic chk(input logic ok, input string t, input int act, input int e);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", t, act, e);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [15:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic unlock;
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
    endtask

    task automatic prog(input logic [15:0] a, input logic [15:0] d);
        unlock();
        wr(16'h5555, 16'h00A0);
        wr(a, d);
    endtask

    task automatic erase_pre;
        unlock();
        wr(16'h5555, 16'h0080);
        unlock();
    endtask

    task automatic wait_busy(input int e, input string t);
        int n = 0;
        while (busy === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == e, t, n, e);
    endtask

    task automatic wait_idle;
        int n = 0;
        while (busy === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R4 watchdog expired act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(rdata == 16'h0000, "R1 rdata after reset", rdata, 0);
        rd(16'h0000, 16'hFFFF, "R1 erased word 0000");
        rd(16'h0801, 16'hFFFF, "R1 erased word 0801");

        // R3 / R5 program with status reads
        prog(16'h0123, 16'h5A5A);
        rd(16'h0123, 16'h0080, "R5 first program status");
        rd(16'h0555, 16'h00C0, "R5 second program status toggles");
        wait_idle();
        rd(16'h0123, 16'h5A5A, "R2 R3 programmed word");

        // R3 AND semantics, R4 program duration
        prog(16'h0123, 16'hF0F0);
        wait_busy(PROG_N, "R4 program busy length");
        rd(16'h0123, 16'h5050, "R3 program clears bits only");

        // R9 aborted sequences
        unlock();
        wr(16'h5555, 16'h0012);
        wr(16'h5555, 16'h00A0);
        wr(16'h0123, 16'h0000);
        chk(busy == 1'b0, "R9 no start after bad command", busy, 0);
        wr(16'h5555, 16'h00AA);
        wr(16'h5555, 16'h0055);
        wr(16'h5555, 16'h00A0);
        wr(16'h0123, 16'h0000);
        chk(busy == 1'b0, "R9 no start after bad second step", busy, 0);
        rd(16'h0123, 16'h5050, "R9 word unchanged after abort");

        // R8 high bits ignored
        wr(16'hD555, 16'hFFAA);
        wr(16'hAAAA, 16'h1255);
        wr(16'hD555, 16'h77A0);
        wr(16'h0801, 16'h1234);
        chk(busy == 1'b1, "R8 program starts with high bits set", busy, 1);
        wait_idle();
        rd(16'h0801, 16'h1234, "R8 programmed via masked compare");

        // R10 writes ignored while busy
        prog(16'h0002, 16'h00FF);
        prog(16'h0004, 16'h0000);
        wait_idle();
        rd(16'h0004, 16'hFFFF, "R10 sequence during busy ignored");
        rd(16'h0002, 16'h00FF, "R3 second word programmed");

        // R11 / R12 identification
        unlock();
        wr(16'h5555, 16'h0090);
        rd(16'h0000, 16'h00BF, "R11 maker code");
        rd(16'h0001, 16'h2788, "R11 part code");
        rd(16'h0801, 16'h1234, "R11 other address reads array");
        rd(16'h8000, 16'hFFFF, "R11 bit15 set reads array");
        wr(16'h1234, 16'h00F0);
        rd(16'h0001, 16'hFFFF, "R12 single write exit");
        unlock();
        wr(16'h5555, 16'h0090);
        rd(16'h0000, 16'h00BF, "R11 maker code again");
        unlock();
        wr(16'h5555, 16'h00F0);
        rd(16'h0000, 16'hFFFF, "R12 three write exit");

        // R6 sector erase with status reads
        erase_pre();
        wr(16'h0FFF, 16'h0030);
        rd(16'h0000, 16'h0000, "R5 first erase status");
        rd(16'h0000, 16'h0040, "R5 second erase status toggles");
        wait_idle();
        rd(16'h0801, 16'hFFFF, "R6 erased sector word");
        rd(16'h0123, 16'h5050, "R6 other sector kept");

        // R4 sector duration, R6 sector 0
        erase_pre();
        wr(16'h0005, 16'h0030);
        wait_busy(SECT_N, "R4 sector erase busy length");
        rd(16'h0123, 16'hFFFF, "R6 sector zero erased");

        // R7 chip erase
        prog(16'h1803, 16'h0F0F);
        wait_idle();
        rd(16'h1803, 16'h0F0F, "R3 sector three word");
        erase_pre();
        wr(16'h5555, 16'h0010);
        wait_busy(CHIP_N, "R4 chip erase busy length");
        rd(16'h1803, 16'hFFFF, "R7 chip erase sector three");
        rd(16'h0002, 16'hFFFF, "R7 chip erase sector zero");

        finish_run();
    end

endmodule